// File: doc/BRIEF.md
# Masked Interrupt Flag Controller

This block gathers the interrupt events of a small peripheral into one interrupt line. There are three sources: two timers and a shift register. Each source gives a one-cycle set pulse, and the matching bit of a flag register stays pending until software clears it. An enable register selects which pending flags may drive the interrupt output. The output is a level, high while any enabled flag is pending.

Software reaches both registers through a byte-wide port, chosen by a one-bit register select. A write to the flag register acknowledges events: each data bit at 1 clears the matching flag. A write to the enable register uses its top bit to choose between setting and clearing the enable bits marked by ones in the lower seven bits. Reads of other registers in the peripheral can clear a flag as a side effect. Those reads arrive here as per-source clear strobes.

Top module: `irq_flag_ctrl`

## Requirements
- R1: `irq` is high exactly when some bit is 1 in both the flag register and the enable register. It follows the register contents in the same cycle as the clock edge that updates them.
- R2: With `reg_sel` = 0, `rdata` returns the flag register in bits 6..0, and bit 7 is 1 exactly when an enabled flag is pending.
- R3: With `reg_sel` = 1, `rdata` returns the enable register in bits 6..0, and bit 7 always reads 1.
- R4: A write with `reg_sel` = 1 and `wdata[7]` = 1 sets every enable bit whose `wdata` bit (6..0) is 1. With `wdata[7]` = 0 it clears every enable bit whose `wdata` bit is 1. All other enable bits keep their value.
- R5: A write with `reg_sel` = 0 clears every flag whose `wdata` bit is 1 and leaves the other flags unchanged.
- R6: `t1_rdclr` clears the timer-1 flag, `t2_rdclr` clears the timer-2 flag, and `sr_rdclr` clears the shift-register flag, each on the next clock edge.
- R7: `t1_set` sets flag bit 6, `t2_set` sets flag bit 5 and `sr_set` sets flag bit 2. Flag bits 4, 3, 1 and 0 always read 0.
- R8: When a set pulse and a clear (a clear strobe or a flag-register write) hit the same flag in the same cycle, the flag ends up set.
- R9: Reset (`rst_n` low) clears both registers, so `irq` is low and the enable register reads 0x80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the flag register, 1 selects the enable register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data of the selected register |
| t1_set | input | 1 | Timer-1 event pulse |
| t2_set | input | 1 | Timer-2 event pulse |
| sr_set | input | 1 | Shift-register event pulse |
| t1_rdclr | input | 1 | Timer-1 flag clear strobe (read side effect) |
| t2_rdclr | input | 1 | Timer-2 flag clear strobe (read side effect) |
| sr_rdclr | input | 1 | Shift-register flag clear strobe (read side effect) |
| irq | output | 1 | Level interrupt output |

## Verification
Every write, set pulse or clear strobe takes effect at the next rising edge. `irq` and `rdata` are combinational from the registers, so their new values are visible right after that same edge. The bench drives stimulus on the falling edge and holds it through one rising edge. On the following falling edge it drops all strobes, sets `reg_sel` to the register under check, and samples shortly afterwards. Each result is therefore checked exactly one edge after its cause, and no later event can mask it.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int W      = 8,
  parameter int T1_POS = 6,
  parameter int T2_POS = 5,
  parameter int SR_POS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         reg_sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         t1_set,
  input  logic         t2_set,
  input  logic         sr_set,
  input  logic         t1_rdclr,
  input  logic         t2_rdclr,
  input  logic         sr_rdclr,
  output logic         irq
);
  localparam int FW = W - 1;
  localparam logic [FW-1:0] SRC_MASK =
    FW'((1 << T1_POS) | (1 << T2_POS) | (1 << SR_POS));

  logic [FW-1:0] flag_q, en_q;
  logic [FW-1:0] set_v, rdclr_v, wclr_v;
  logic          pend;

  always_comb begin
    set_v = '0;
    rdclr_v = '0;
    set_v[T1_POS]   = t1_set;
    set_v[T2_POS]   = t2_set;
    set_v[SR_POS]   = sr_set;
    rdclr_v[T1_POS] = t1_rdclr;
    rdclr_v[T2_POS] = t2_rdclr;
    rdclr_v[SR_POS] = sr_rdclr;
  end

  assign wclr_v = (wr_en && !reg_sel) ? wdata[FW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= ((flag_q & ~(wclr_v | rdclr_v)) | set_v) & SRC_MASK;
      if (wr_en && reg_sel)
        en_q <= wdata[W-1] ? (en_q | wdata[FW-1:0]) : (en_q & ~wdata[FW-1:0]);
    end
  end

  assign pend  = |(flag_q & en_q);
  assign irq   = pend;
  assign rdata = reg_sel ? {1'b1, en_q} : {pend, flag_q};

  assert_sum_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (rdata[W-1] == irq));
  assert_en_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> rdata[W-1]);
  assert_en_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel && wdata[W-1]) |=>
      ((en_q & $past(wdata[FW-1:0])) == $past(wdata[FW-1:0])));
  assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel && !wdata[W-1]) |=>
      ((en_q & $past(wdata[FW-1:0])) == '0));
  assert_flag_wclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel && wdata[SR_POS] && !sr_set) |=> !flag_q[SR_POS]);
  assert_rdclr_t1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_rdclr && !t1_set) |=> !flag_q[T1_POS]);
  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> ((rdata[FW-1:0] & ~SRC_MASK) == '0));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    t2_set |=> flag_q[T2_POS]);
endmodule

// File: tb/tb_irq_flag_ctrl.sv
`timescale 1ns/1ps
module tb_irq_flag_ctrl;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, reg_sel = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic t1_set = 0, t2_set = 0, sr_set = 0;
  logic t1_rdclr = 0, t2_rdclr = 0, sr_rdclr = 0;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_flag_ctrl dut (.clk, .rst_n, .wr_en, .reg_sel, .wdata, .rdata,
    .t1_set, .t2_set, .sr_set, .t1_rdclr, .t2_rdclr, .sr_rdclr, .irq);

  // {wr, sel, wdata[8], set{t1,t2,sr}[3], clr{t1,t2,sr}[3], chk_sel, exp_rdata[8], exp_irq}
  localparam int NV = 13;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0,1'b0,8'h00,3'b100,3'b000,1'b0,8'h40,1'b0}, // R7 t1 bit6
    {1'b1,1'b1,8'hC0,3'b000,3'b000,1'b0,8'hC0,1'b1}, // R4 R1 R2
    {1'b0,1'b0,8'h00,3'b000,3'b000,1'b1,8'hC0,1'b1}, // R3
    {1'b0,1'b0,8'h00,3'b001,3'b000,1'b0,8'hC4,1'b1}, // R7 sr bit2
    {1'b1,1'b0,8'h40,3'b000,3'b000,1'b0,8'h04,1'b0}, // R5 R2
    {1'b1,1'b1,8'h84,3'b000,3'b000,1'b0,8'h84,1'b1}, // R4 R1
    {1'b0,1'b0,8'h00,3'b000,3'b001,1'b0,8'h00,1'b0}, // R6 sr
    {1'b0,1'b0,8'h00,3'b010,3'b000,1'b0,8'h20,1'b0}, // R7 t2 bit5
    {1'b1,1'b1,8'hA0,3'b000,3'b000,1'b1,8'hE4,1'b1}, // R4 set
    {1'b1,1'b1,8'h40,3'b000,3'b000,1'b1,8'hA4,1'b1}, // R4 clear
    {1'b0,1'b0,8'h00,3'b000,3'b010,1'b0,8'h00,1'b0}, // R6 t2
    {1'b0,1'b0,8'h00,3'b111,3'b000,1'b0,8'hE4,1'b1}, // R7 R2
    {1'b1,1'b0,8'hFF,3'b000,3'b000,1'b0,8'h00,1'b0}  // R5 all
  };

  task automatic apply(input logic w, input logic s, input logic [7:0] d,
                       input logic [2:0] st, input logic [2:0] cl);
    @(negedge clk);
    wr_en = w; reg_sel = s; wdata = d;
    {t1_set, t2_set, sr_set} = st;
    {t1_rdclr, t2_rdclr, sr_rdclr} = cl;
  endtask

  task automatic check(input string req, input logic s,
                       input logic [7:0] er, input logic ei);
    @(negedge clk);
    wr_en = 0; wdata = 0; reg_sel = s;
    {t1_set, t2_set, sr_set} = 3'b000;
    {t1_rdclr, t2_rdclr, sr_rdclr} = 3'b000;
    #1;
    n_run++;
    if (rdata !== er || irq !== ei) begin
      n_fail++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", req, rdata, irq, er, ei);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    #1; n_run++;
    if (irq !== 0 || rdata !== 8'h00) begin
      n_fail++; $display("FAIL R9: rdata=%h irq=%b expected 00/0", rdata, irq);
    end
    rst_n = 1;
    check("R9 en", 1'b1, 8'h80, 1'b0);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:13], VEC[i][12:10]);
      check($sformatf("vec%0d", i), VEC[i][9], VEC[i][8:1], VEC[i][0]);
    end
    // R8 set beats clear strobe
    apply(1'b0, 1'b0, 8'h00, 3'b100, 3'b100);
    check("R8 strobe", 1'b0, 8'h40, 1'b0);
    // R8 set beats flag write
    apply(1'b1, 1'b0, 8'h24, 3'b011, 3'b000);
    check("R8 write", 1'b0, 8'hE4, 1'b1);
    // R6 t1 clear
    apply(1'b0, 1'b0, 8'h00, 3'b000, 3'b100);
    check("R6 t1", 1'b0, 8'hA4, 1'b1);
    // R4 set with no data bits changes nothing
    apply(1'b1, 1'b1, 8'h80, 3'b000, 3'b000);
    check("R4 noop", 1'b1, 8'hA4, 1'b1);
    // R9 reset mid-run
    @(negedge clk); rst_n = 0;
    check("R9 flags", 1'b0, 8'h00, 1'b0);
    check("R9 enables", 1'b1, 8'h80, 1'b0);
    rst_n = 1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule